// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Decoder

This block sits on the CPU write path of a game-cartridge memory mapper. It watches CPU writes to the upper half of the 16-bit address space and decodes them into bank-selection state. That state is two switchable 8 KB program banks, eight 1 KB character banks and a 2-bit nametable mirroring code. The block then translates CPU read addresses and video pattern-fetch addresses into physical ROM addresses, which go straight to the program and character ROM devices.

Program space above 0x8000 is cut into four 8 KB windows. The lower two windows follow software-written bank numbers. The upper two are tied to the two highest banks of the program ROM. Each character bank number is 8 bits wide, but software loads it 4 bits at a time through a pair of addresses, one for each nibble. Every bank number is reduced modulo the number of banks the fitted ROM holds, so software can write any byte without addressing past the end of the ROM.

Top module: `mapper_bank_decoder`

## Requirements
- R1: After reset, all eight character bank numbers are 0, the mirroring code is 0, and the four program windows (0x8000, 0xA000, 0xC000, 0xE000) map to banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1.
- R2: A write to exactly 0x8000 loads cpu_data as the bank number of the window that starts at 0x8000.
- R3: A write to exactly 0xA000 loads cpu_data as the bank number of the window that starts at 0xA000. The windows at 0xC000 and 0xE000 always map to banks PRG_BANKS-2 and PRG_BANKS-1.
- R4: A write to exactly 0x9000 loads cpu_data[1:0] into mirror_mode, with codes 0 vertical, 1 horizontal, 2 single-screen low page and 3 single-screen high page. Data bits [7:2] are ignored.
- R5: Character bank k (k = 0..7) is written at address 0xB000 + (k/2)*0x1000 + (k%2)*2 for its low nibble, and at that address + 1 for its high nibble.
- R6: A low-nibble write replaces bits [3:0] of the bank number with cpu_data[3:0]. A high-nibble write replaces bits [7:4] with cpu_data[3:0]. The other nibble is kept, and cpu_data[7:4] is ignored.
- R7: chr_rom_addr = {bank of slot ppu_addr[12:10], ppu_addr[9:0]}.
- R8: prg_rom_addr = {bank of window cpu_addr[14:13], cpu_addr[12:0]}, where window 0 is 0x8000, 1 is 0xA000, 2 is 0xC000 and 3 is 0xE000.
- R9: A write whose 16-bit address matches none of the addresses above, or any cycle with cpu_we low, changes no bank number and no mirroring code.
- R10: A switchable program bank number is applied modulo PRG_BANKS, and a character bank number modulo CHR_BANKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for writes and for program translation |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video pattern-space address |
| prg_rom_addr | output | PRG_BW+13 | Physical program ROM address |
| chr_rom_addr | output | CHR_BW+10 | Physical character ROM address |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The case hardest to reach from the ports is a write that lands near a valid register without hitting it. Examples are an offset one past the last nibble address, an address that aliases a register in its low 12 bits, or the right address with the strobe low. None of these writes shows up on an output at once. The stimulus therefore first loads distinct values into every character bank, then sends a series of near-miss writes, and then reads all eight slots, both program windows and the mirroring code back through the translated addresses. Modulo reduction is only visible with a bank count that is not a power of two, so the bench builds the block with 24 program banks.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int CPU_AW      = 16;
  localparam int CPU_DW      = 8;
  localparam int PPU_AW      = 13;
  localparam int PRG_PAGE_AW = 13;   // 8 KB program window
  localparam int CHR_PAGE_AW = 10;   // 1 KB character slot
  localparam int CHR_SLOTS   = 8;
  localparam int NIB_W       = 4;

  localparam logic [CPU_AW-1:0] ADDR_PRG_WIN0 = 16'h8000;
  localparam logic [CPU_AW-1:0] ADDR_PRG_WIN1 = 16'hA000;
  localparam logic [CPU_AW-1:0] ADDR_MIRROR   = 16'h9000;
  localparam int                CHR_BASE      = 'hB000;
  localparam int                CHR_STRIDE    = 'h1000;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORIZ  = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  // Address of the low-nibble port of character bank k
  function automatic int chr_lo_port(int k);
    return CHR_BASE + (k / 2) * CHR_STRIDE + (k % 2) * 2;
  endfunction

  // Reduce a raw bank number to the banks actually fitted
  function automatic int wrap_bank(int raw, int count);
    return raw % count;
  endfunction

  // Bit width needed to index count banks (at least one bit)
  function automatic int bank_bits(int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/mapper_wr_decode.sv
module mapper_wr_decode
  import mapper_pkg::*;
(
  input  logic                 cpu_we,
  input  logic [CPU_AW-1:0]    cpu_addr,
  output logic                 hit_prg0,
  output logic                 hit_prg1,
  output logic                 hit_mir,
  output logic [CHR_SLOTS-1:0] hit_chr_lo,
  output logic [CHR_SLOTS-1:0] hit_chr_hi
);

  assign hit_prg0 = cpu_we && (cpu_addr == ADDR_PRG_WIN0);
  assign hit_prg1 = cpu_we && (cpu_addr == ADDR_PRG_WIN1);
  assign hit_mir  = cpu_we && (cpu_addr == ADDR_MIRROR);

  for (genvar k = 0; k < CHR_SLOTS; k++) begin : g_chr_port
    localparam logic [CPU_AW-1:0] LO_PORT = CPU_AW'(chr_lo_port(k));
    localparam logic [CPU_AW-1:0] HI_PORT = CPU_AW'(chr_lo_port(k) + 1);
    assign hit_chr_lo[k] = cpu_we && (cpu_addr == LO_PORT);
    assign hit_chr_hi[k] = cpu_we && (cpu_addr == HI_PORT);
  end

endmodule

// File: rtl/mapper_chr_banks.sv
module mapper_chr_banks
  import mapper_pkg::*;
#(
  parameter int CHR_BANKS = 128,
  localparam int CHR_BW   = bank_bits(CHR_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHR_SLOTS-1:0] hit_lo,
  input  logic [CHR_SLOTS-1:0] hit_hi,
  input  logic [NIB_W-1:0]     nibble,
  input  logic [PPU_AW-1:0]    ppu_addr,
  output logic [CHR_BW+CHR_PAGE_AW-1:0] chr_rom_addr
);

  localparam int SLOT_W = $clog2(CHR_SLOTS);

  logic [CHR_SLOTS-1:0][CPU_DW-1:0] bank_q;

  for (genvar k = 0; k < CHR_SLOTS; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[k] <= '0;
      end else begin
        if (hit_lo[k]) bank_q[k][NIB_W-1:0]      <= nibble;
        if (hit_hi[k]) bank_q[k][CPU_DW-1:NIB_W] <= nibble;
      end
    end
  end

  logic [SLOT_W-1:0] slot;
  logic [CHR_BW-1:0] eff_bank;

  assign slot     = ppu_addr[CHR_PAGE_AW +: SLOT_W];
  assign eff_bank = CHR_BW'(wrap_bank(int'(bank_q[slot]), CHR_BANKS));
  assign chr_rom_addr = {eff_bank, ppu_addr[CHR_PAGE_AW-1:0]};

endmodule

// File: rtl/mapper_prg_ctrl.sv
module mapper_prg_ctrl
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  localparam int PRG_BW   = bank_bits(PRG_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_prg0,
  input  logic                 hit_prg1,
  input  logic                 hit_mir,
  input  logic [CPU_DW-1:0]    cpu_data,
  input  logic [1:0]           win_sel,
  input  logic [PRG_PAGE_AW-1:0] page_off,
  output logic [PRG_BW+PRG_PAGE_AW-1:0] prg_rom_addr,
  output logic [1:0]           mirror_mode
);

  logic [CPU_DW-1:0] win0_q, win1_q;
  mirror_e           mir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win0_q <= CPU_DW'(0);
      win1_q <= CPU_DW'(1);
      mir_q  <= MIR_VERT;
    end else begin
      if (hit_prg0) win0_q <= cpu_data;
      if (hit_prg1) win1_q <= cpu_data;
      if (hit_mir)  mir_q  <= mirror_e'(cpu_data[1:0]);
    end
  end

  logic [PRG_BW-1:0] eff_bank;

  always_comb begin
    unique case (win_sel)
      2'd0:    eff_bank = PRG_BW'(wrap_bank(int'(win0_q), PRG_BANKS));
      2'd1:    eff_bank = PRG_BW'(wrap_bank(int'(win1_q), PRG_BANKS));
      2'd2:    eff_bank = PRG_BW'(PRG_BANKS - 2);
      default: eff_bank = PRG_BW'(PRG_BANKS - 1);
    endcase
  end

  assign prg_rom_addr = {eff_bank, page_off};
  assign mirror_mode  = mir_q;

endmodule

// File: rtl/mapper_bank_decoder.sv
module mapper_bank_decoder
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int CHR_BANKS = 128,
  localparam int PRG_BW   = bank_bits(PRG_BANKS),
  localparam int CHR_BW   = bank_bits(CHR_BANKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_we,
  input  logic [15:0]                     cpu_addr,
  input  logic [7:0]                      cpu_data,
  input  logic [12:0]                     ppu_addr,
  output logic [PRG_BW+PRG_PAGE_AW-1:0]   prg_rom_addr,
  output logic [CHR_BW+CHR_PAGE_AW-1:0]   chr_rom_addr,
  output logic [1:0]                      mirror_mode
);

  localparam int STROBE_W = 3 + 2 * CHR_SLOTS;

  logic                 hit_prg0, hit_prg1, hit_mir;
  logic [CHR_SLOTS-1:0] hit_chr_lo, hit_chr_hi;
  logic [STROBE_W-1:0]  wr_strobes;   // every decoded write event, for checking

  assign wr_strobes = {hit_prg0, hit_prg1, hit_mir, hit_chr_lo, hit_chr_hi};

  mapper_wr_decode u_dec (
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .hit_prg0   (hit_prg0),
    .hit_prg1   (hit_prg1),
    .hit_mir    (hit_mir),
    .hit_chr_lo (hit_chr_lo),
    .hit_chr_hi (hit_chr_hi)
  );

  mapper_prg_ctrl #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_prg0     (hit_prg0),
    .hit_prg1     (hit_prg1),
    .hit_mir      (hit_mir),
    .cpu_data     (cpu_data),
    .win_sel      (cpu_addr[14:13]),
    .page_off     (cpu_addr[PRG_PAGE_AW-1:0]),
    .prg_rom_addr (prg_rom_addr),
    .mirror_mode  (mirror_mode)
  );

  mapper_chr_banks #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_lo       (hit_chr_lo),
    .hit_hi       (hit_chr_hi),
    .nibble       (cpu_data[NIB_W-1:0]),
    .ppu_addr     (ppu_addr),
    .chr_rom_addr (chr_rom_addr)
  );

endmodule

// File: rtl/mapper_bank_decoder_chk.sv
module mapper_bank_decoder_chk
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int CHR_BANKS = 128,
  parameter int STROBE_W  = 19,
  localparam int PRG_BW   = bank_bits(PRG_BANKS),
  localparam int CHR_BW   = bank_bits(CHR_BANKS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_we,
  input logic [15:0]                   cpu_addr,
  input logic [7:0]                    cpu_data,
  input logic [12:0]                   ppu_addr,
  input logic [PRG_BW+PRG_PAGE_AW-1:0] prg_rom_addr,
  input logic [CHR_BW+CHR_PAGE_AW-1:0] chr_rom_addr,
  input logic [1:0]                    mirror_mode,
  input logic [STROBE_W-1:0]           wr_strobes
);

  localparam logic [PRG_BW-1:0] LAST_PRG = PRG_BW'(PRG_BANKS - 1);
  localparam logic [PRG_BW-1:0] NEXT_PRG = PRG_BW'(PRG_BANKS - 2);

  logic [PRG_BW-1:0] prg_bank;
  logic [CHR_BW-1:0] chr_bank;
  assign prg_bank = prg_rom_addr[PRG_BW+PRG_PAGE_AW-1:PRG_PAGE_AW];
  assign chr_bank = chr_rom_addr[CHR_BW+CHR_PAGE_AW-1:CHR_PAGE_AW];

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobes));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |-> (wr_strobes == '0));

  // R4
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h9000) |=> (mirror_mode == $past(cpu_data[1:0])));

  // R9
  mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr == 16'h9000) |=> $stable(mirror_mode));

  // R8
  prg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rom_addr[PRG_PAGE_AW-1:0] == cpu_addr[PRG_PAGE_AW-1:0]);

  // R3
  prg_top_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'b11) |-> (prg_bank == LAST_PRG));

  // R3
  prg_next_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'b10) |-> (prg_bank == NEXT_PRG));

  // R7
  chr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rom_addr[CHR_PAGE_AW-1:0] == ppu_addr[CHR_PAGE_AW-1:0]);

  // R10
  prg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(prg_bank) < PRG_BANKS);

  // R10
  chr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chr_bank) < CHR_BANKS);

endmodule

bind mapper_bank_decoder mapper_bank_decoder_chk #(
  .PRG_BANKS (PRG_BANKS),
  .CHR_BANKS (CHR_BANKS),
  .STROBE_W  (STROBE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_we       (cpu_we),
  .cpu_addr     (cpu_addr),
  .cpu_data     (cpu_data),
  .ppu_addr     (ppu_addr),
  .prg_rom_addr (prg_rom_addr),
  .chr_rom_addr (chr_rom_addr),
  .mirror_mode  (mirror_mode),
  .wr_strobes   (wr_strobes)
);

// File: tb/mapper_bank_decoder_bench.sv
module mapper_bank_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANKS  = 24;
  localparam int CHR_BANKS  = 128;
  localparam int PRG_AW     = $clog2(PRG_BANKS) + 13;
  localparam int CHR_AW     = $clog2(CHR_BANKS) + 10;

  typedef struct {
    string tag;
    int    kind;     // 0 program address, 1 character address, 2 mirroring
    int    expv;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_we = 1'b0;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_data = '0;
  logic [12:0]       ppu_addr = '0;
  logic [PRG_AW-1:0] prg_rom_addr;
  logic [CHR_AW-1:0] chr_rom_addr;
  logic [1:0]        mirror_mode;

  item_t sb[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // bench-side model of the programmable state
  int m_win0, m_win1, m_mir;
  int m_chr[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mapper_bank_decoder #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_mapper_bank_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .ppu_addr     (ppu_addr),
    .prg_rom_addr (prg_rom_addr),
    .chr_rom_addr (chr_rom_addr),
    .mirror_mode  (mirror_mode)
  );

  // Model of a write, written from the requirement text
  task automatic write(input int a, input int d, input bit we = 1'b1);
    @(negedge clk);
    cpu_we   = we;
    cpu_addr = 16'(a);
    cpu_data = 8'(d);
    if (we) begin
      if (a == 'h8000) m_win0 = d;
      if (a == 'hA000) m_win1 = d;
      if (a == 'h9000) m_mir = d & 3;
      for (int k = 0; k < 8; k++) begin
        int lo = 'hB000 + 'h1000 * (k >> 1) + 2 * (k & 1);
        if (a == lo)     m_chr[k] = (m_chr[k] & 'hF0) | (d & 'hF);
        if (a == lo + 1) m_chr[k] = (m_chr[k] & 'h0F) | ((d & 'hF) * 16);
      end
    end
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic probe_prg(input string tag, input int a);
    int win, bank;
    @(negedge clk);
    cpu_addr = 16'(a);
    win = (a / 8192) % 4;
    case (win)
      0: bank = m_win0 % PRG_BANKS;
      1: bank = m_win1 % PRG_BANKS;
      2: bank = PRG_BANKS - 2;
      default: bank = PRG_BANKS - 1;
    endcase
    sb.push_back('{tag, 0, bank * 8192 + (a % 8192)});
  endtask

  task automatic probe_chr(input string tag, input int p);
    @(negedge clk);
    ppu_addr = 13'(p);
    sb.push_back('{tag, 1, (m_chr[(p / 1024) % 8] % CHR_BANKS) * 1024 + (p % 1024)});
  endtask

  task automatic probe_mir(input string tag);
    @(negedge clk);
    sb.push_back('{tag, 2, m_mir});
  endtask

  task automatic probe_all(input string tag);
    for (int k = 0; k < 8; k++) probe_chr(tag, k * 1024 + 37 * k);
    probe_prg(tag, 'h8000 + 'h0ABC);
    probe_prg(tag, 'hA000 + 'h1234);
    probe_prg(tag, 'hC000 + 'h0042);
    probe_prg(tag, 'hE000 + 'h1FFF);
    probe_mir(tag);
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (sb.size() > 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        case (it.kind)
          0: act = int'(prg_rom_addr);
          1: act = int'(chr_rom_addr);
          default: act = int'(mirror_mode);
        endcase
        n_tests++;
        if (act !== it.expv) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.expv);
        end
      end
    end
  end

  initial begin
    m_win0 = 0; m_win1 = 1; m_mir = 0;
    for (int k = 0; k < 8; k++) m_chr[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe_all("R1");

    // R2 switchable window at 0x8000
    write('h8000, 7);
    probe_prg("R2", 'h8123);
    probe_prg("R2", 'h9FFF);

    // R3 window at 0xA000, upper windows fixed
    write('hA000, 'h0B);
    probe_prg("R3", 'hA456);
    probe_prg("R3", 'hC000);
    probe_prg("R3", 'hFFFF);

    // R4 every mirroring code, with upper data bits set
    write('h9000, 'hFE); probe_mir("R4");
    write('h9000, 'h03); probe_mir("R4");
    write('h9000, 'h01); probe_mir("R4");
    write('h9000, 'hFC); probe_mir("R4");
    write('h9000, 'h02); probe_mir("R4");

    // R5 distinct value into every character bank through both ports
    for (int k = 0; k < 8; k++) begin
      int lo = 'hB000 + 'h1000 * (k >> 1) + 2 * (k & 1);
      write(lo, 'hF0 | (k + 3));
      write(lo + 1, 'hA0 | (7 - k));
    end
    for (int k = 0; k < 8; k++) probe_chr("R5", k * 1024 + k);

    // R6 one nibble replaced, the other kept
    write('hC003, 'h5C);
    probe_chr("R6", 3 * 1024 + 5);
    write('hD002, 'h29);
    probe_chr("R6", 5 * 1024 + 6);

    // R7 offsets across a slot and slot edges
    probe_chr("R7", 0);
    probe_chr("R7", 1023);
    probe_chr("R7", 1024);
    probe_chr("R7", 8191);

    // R8 program offsets at window edges
    probe_prg("R8", 'h8000);
    probe_prg("R8", 'hBFFF);
    probe_prg("R8", 'hDFFF);

    // R9 near-miss writes and strobe-low writes have no effect
    write('h8001, 'h11);
    write('hA001, 'h12);
    write('h9001, 'h03);
    write('hB004, 'h0F);
    write('hC010, 'h0F);
    write('hE004, 'h0F);
    write('hF000, 'h0F);
    write('hF003, 'h0F);
    write('h7000, 'h0F);
    write('h3000, 'h0F);
    write('h0B00, 'h0F);
    write('h8000, 'h13, 1'b0);
    write('h9000, 'h00, 1'b0);
    write('hE003, 'h09, 1'b0);
    probe_all("R9");

    // R10 bank numbers beyond the ROM wrap
    write('h8000, 'h25);
    write('hA000, 'hFF);
    write('hE002, 'h05);
    write('hE003, 'h0C);
    probe_prg("R10", 'h8777);
    probe_prg("R10", 'hA777);
    probe_chr("R10", 7 * 1024 + 99);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule